// File: doc/BRIEF.md
# DAQ Sample Capture and Byte Packetizer

This block sits between an acquisition board and a byte-wide host link. Two serial sample lines are shifted in together, one bit per cycle in which the shift enable is high. After a full frame, the block holds both channel results as parallel words. A mode input then picks the 24-bit word to forward. In analog mode, the word is the two channel samples side by side. In digital mode, it is a 12-bit parallel input word, zero-extended.

A small state machine takes each completed word. It raises a one-cycle read strobe, then writes the word as three bytes into a downstream byte FIFO. The FIFO is seen only through a write enable, a byte bus and a full flag. Writes wait while the FIFO reports full. If a new word completes while a packet is still in progress, that word is dropped and a sticky overrun flag is raised.

At a 20 ksample/s acquisition rate, a frame lasts far longer than a packet. An overrun therefore means that the FIFO has stalled for a long time.

Top module: `daq_byte_packer`

## Requirements
- R1: A synchronous active-high reset clears the state as follows:
  - `fifo_wr`, `word_rd`, `overrun` and `fifo_data` read zero.
  - The shift bit counter and the shift registers are cleared, so any partly shifted frame is lost.
- R2: Each channel shifts in most significant bit first, one bit per cycle with `shift_en` high. Cycles with `shift_en` low change nothing. A word completes on exactly the 12th enabled shift. Eleven shifts produce no output.
- R3: In analog mode (`dig_mode`=0), the word is formed as follows:
  - channel 0 (`ser_in[0]`) sits in bits 23:12;
  - channel 1 (`ser_in[1]`) sits in bits 11:0;
  - `dig_in` has no effect.
- R4: In digital mode (`dig_mode`=1), the word is `dig_in` in bits 11:0 with bits 23:12 zero. The serial data has no effect. The mode and `dig_in` are taken one cycle after the 12th shift.
- R5: Each accepted word produces the following at the ports:
  - exactly one single-cycle `word_rd` pulse;
  - then exactly three FIFO writes.
  - `word_rd` and `fifo_wr` are never high together.
- R6: The three bytes of a word go out most significant first: bits 23:16, then 15:8, then 7:0.
- R7: While `fifo_full` is high, `fifo_wr` is low and the pending byte stays on `fifo_data`. The packet resumes without loss when `fifo_full` falls.
- R8: When no packet is in progress, `fifo_data` is zero and both `fifo_wr` and `word_rd` are low.
- R9: A word that completes while a previous word is still being read or written is discarded, and it sets `overrun`. `overrun` stays high until reset. It never sets when words arrive only while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Shift one serial bit per channel this cycle |
| ser_in | input | 2 | Serial sample bits, index 0 = channel 0 |
| dig_in | input | 12 | Parallel digital input word |
| dig_mode | input | 1 | 1 selects the digital word, 0 the two analog samples |
| fifo_full | input | 1 | Downstream byte FIFO cannot accept a byte |
| fifo_wr | output | 1 | Byte write strobe to the FIFO |
| fifo_data | output | 8 | Byte to the FIFO |
| word_rd | output | 1 | One-cycle strobe when a word is taken for packing |
| overrun | output | 1 | Sticky flag: a word was dropped |

## Verification
The assertions check several properties on every cycle:
- the read strobe is a single cycle and is followed by the write phase;
- no write happens while the FIFO is full, and the byte stays stable under back-pressure;
- the bus is quiet when idle;
- digital words are zero-extended;
- completions come from enabled shifts;
- the overrun flag is sticky.

Only the bench scenarios can show the following:
- the actual byte values and their order;
- that exactly twelve shifts are needed and that gaps are ignored;
- the mode selection across swept values;
- that a reset discards a half-shifted frame;
- that a word arriving during a stalled packet is dropped while the earlier word still comes out intact.

// File: rtl/daq_pkg.sv
package daq_pkg;
  typedef enum logic [1:0] {
    PK_IDLE = 2'd0,
    PK_READ = 2'd1,
    PK_EMIT = 2'd2
  } pk_state_t;
endpackage

// File: rtl/daq_shift_capture.sv
module daq_shift_capture #(
  parameter int SAMPLE_W = 12,
  parameter int NUM_CH   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         shift_en,
  input  logic [NUM_CH-1:0]            ser_in,
  output logic [NUM_CH*SAMPLE_W-1:0]   word_o,
  output logic                         valid_o
);
  localparam int CNT_W  = $clog2(SAMPLE_W);
  localparam int WORD_W = NUM_CH * SAMPLE_W;

  logic [CNT_W-1:0] bit_cnt;
  logic             last_bit;

  assign last_bit = (bit_cnt == CNT_W'(SAMPLE_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= shift_en && last_bit;
      if (shift_en) begin
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] held;
    always_ff @(posedge clk) begin
      if (rst) begin
        shreg <= '0;
        held  <= '0;
      end else if (shift_en) begin
        shreg <= {shreg[SAMPLE_W-2:0], ser_in[c]};
        if (last_bit) begin
          held <= {shreg[SAMPLE_W-2:0], ser_in[c]};
        end
      end
    end
    assign word_o[WORD_W-1-c*SAMPLE_W -: SAMPLE_W] = held;
  end

  AST_DONE_NEEDS_SHIFT: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(shift_en)) else $error("completion without shift"); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o) else $error("back-to-back completions"); // R2
endmodule

// File: rtl/daq_word_select.sv
module daq_word_select #(
  parameter int WORD_W = 24,
  parameter int DIG_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] cap_word,
  input  logic              cap_valid,
  input  logic [DIG_W-1:0]  dig_in,
  input  logic              dig_mode,
  output logic [WORD_W-1:0] sel_word,
  output logic              sel_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_word  <= '0;
      sel_valid <= 1'b0;
    end else begin
      sel_valid <= cap_valid;
      if (cap_valid) begin
        sel_word <= dig_mode ? WORD_W'(dig_in) : cap_word;
      end
    end
  end

  AST_DIG_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && $past(dig_mode)) |-> (sel_word[WORD_W-1:DIG_W] == '0))
    else $error("digital word not zero-extended"); // R4
endmodule

// File: rtl/daq_packetizer.sv
module daq_packetizer
  import daq_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [BYTE_W-1:0] fifo_data,
  output logic              word_rd,
  output logic              overrun
);
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  pk_state_t         state;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] shifted;
  logic              last_byte;

  assign last_byte = (idx == IDX_W'(NBYTES - 1));
  assign shifted   = word_q << (BYTE_W * idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PK_IDLE;
      idx     <= '0;
      word_q  <= '0;
      overrun <= 1'b0;
    end else begin
      if (in_valid && state != PK_IDLE) begin
        overrun <= 1'b1;
      end
      case (state)
        PK_IDLE: begin
          if (in_valid) state <= PK_READ;
        end
        PK_READ: begin
          word_q <= in_word;
          idx    <= '0;
          state  <= PK_EMIT;
        end
        PK_EMIT: begin
          if (!fifo_full) begin
            if (last_byte) begin
              idx   <= '0;
              state <= PK_IDLE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: state <= PK_IDLE;
      endcase
    end
  end

  assign word_rd   = (state == PK_READ);
  assign fifo_wr   = (state == PK_EMIT) && !fifo_full;
  assign fifo_data = (state == PK_EMIT) ? shifted[WORD_W-1 -: BYTE_W] : '0;

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    word_rd |=> !word_rd) else $error("read strobe too long"); // R5

  AST_RD_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    word_rd |=> (fifo_wr || fifo_full)) else $error("no write phase after read"); // R5

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(word_rd && fifo_wr)) else $error("read and write together"); // R5

  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !fifo_wr) else $error("write into full FIFO"); // R7

  AST_HOLD_ON_FULL: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && state == PK_EMIT) |=> $stable(fifo_data))
    else $error("byte changed under back-pressure"); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == PK_IDLE) |-> (fifo_data == '0 && !fifo_wr && !word_rd))
    else $error("bus active while idle"); // R8

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun) else $error("overrun cleared"); // R9
endmodule

// File: rtl/daq_byte_packer.sv
module daq_byte_packer #(
  parameter int SAMPLE_W = 12,
  parameter int NUM_CH   = 2,
  parameter int DIG_W    = 12,
  parameter int BYTE_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic [NUM_CH-1:0]   ser_in,
  input  logic [DIG_W-1:0]    dig_in,
  input  logic                dig_mode,
  input  logic                fifo_full,
  output logic                fifo_wr,
  output logic [BYTE_W-1:0]   fifo_data,
  output logic                word_rd,
  output logic                overrun
);
  localparam int WORD_W = NUM_CH * SAMPLE_W;

  logic [WORD_W-1:0] cap_word;
  logic              cap_valid;
  logic [WORD_W-1:0] sel_word;
  logic              sel_valid;

  daq_shift_capture #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) u_cap (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
    .word_o(cap_word), .valid_o(cap_valid)
  );

  daq_word_select #(.WORD_W(WORD_W), .DIG_W(DIG_W)) u_sel (
    .clk(clk), .rst(rst), .cap_word(cap_word), .cap_valid(cap_valid),
    .dig_in(dig_in), .dig_mode(dig_mode),
    .sel_word(sel_word), .sel_valid(sel_valid)
  );

  daq_packetizer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_pk (
    .clk(clk), .rst(rst), .in_word(sel_word), .in_valid(sel_valid),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .word_rd(word_rd), .overrun(overrun)
  );
endmodule

// File: tb/sim_daq_byte_packer.sv
module sim_daq_byte_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        shift_en = 1'b0;
  logic [1:0]  ser_in = 2'b00;
  logic [11:0] dig_in = '0;
  logic        dig_mode = 1'b0;
  logic        fifo_full = 1'b0;
  logic        fifo_wr;
  logic [7:0]  fifo_data;
  logic        word_rd;
  logic        overrun;

  int checks = 0;
  int failures = 0;
  int ng = 0;
  int nrd = 0;
  int rd_ptr = 0;
  int rd_base = 0;
  logic [7:0] got [0:1023];

  always #4 clk = ~clk;

  daq_byte_packer u0 (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
    .dig_in(dig_in), .dig_mode(dig_mode), .fifo_full(fifo_full),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .word_rd(word_rd),
    .overrun(overrun)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (fifo_wr && ng < 1024) begin
        got[ng] = fifo_data;
        ng++;
      end
      if (word_rd) nrd++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; shift_en = 1'b0; fifo_full = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd_ptr = ng; rd_base = nrd;
  endtask

  task automatic shift_one(input logic x, input logic y);
    @(negedge clk); shift_en = 1'b1; ser_in = {y, x};
    @(negedge clk); shift_en = 1'b0; ser_in = ~ser_in;
  endtask

  task automatic shift_bits(input logic [11:0] a, input logic [11:0] b, input int from, input int upto);
    for (int k = from; k < upto; k++) shift_one(a[11-k], b[11-k]);
  endtask

  task automatic drain(input bit stall);
    for (int k = 0; k < 24; k++) begin
      @(negedge clk); fifo_full = stall ? (k % 3 != 2) : 1'b0;
    end
    @(negedge clk); fifo_full = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [23:0] calc(input bit m, input logic [11:0] a, input logic [11:0] b, input logic [11:0] d);
    return m ? {12'h000, d} : {a, b};
  endfunction

  task automatic expect_word(input logic [23:0] w, input string tag);
    check(ng - rd_ptr == 3, {tag, " R5 byte count"}, ng - rd_ptr, 3);
    check(nrd - rd_base == 1, {tag, " R5 read strobes"}, nrd - rd_base, 1);
    if (ng - rd_ptr >= 3)
      check({got[rd_ptr], got[rd_ptr+1], got[rd_ptr+2]} == w, {tag, " R6 bytes"},
            int'({got[rd_ptr], got[rd_ptr+1], got[rd_ptr+2]}), int'(w));
    check(fifo_data == 8'h00 && !fifo_wr && !word_rd, {tag, " R8 idle bus"}, int'(fifo_data), 0);
    rd_ptr = ng; rd_base = nrd;
  endtask

  task automatic frame(input bit m, input logic [11:0] a, input logic [11:0] b,
                       input logic [11:0] d, input bit stall, input string tag);
    dig_mode = m; dig_in = d;
    shift_bits(a, b, 0, 12);
    drain(stall);
    expect_word(calc(m, a, b, d), tag);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [11:0] a, b, d;
    do_reset();
    @(negedge clk);
    check(!fifo_wr && !word_rd && fifo_data == 0 && !overrun, "R1 reset outputs",
          int'({fifo_wr, word_rd, overrun, fifo_data}), 0);

    // R1: partial frame discarded by reset
    shift_bits(12'hFFF, 12'hFFF, 0, 5);
    do_reset();
    frame(1'b0, 12'h5A3, 12'h0C7, 12'h000, 1'b0, "R1 partial frame cleared");

    // R2: eleven shifts give nothing, the twelfth completes
    dig_mode = 1'b0;
    shift_bits(12'h9B4, 12'h361, 0, 11);
    drain(1'b0);
    check(ng == rd_ptr, "R2 eleven shifts no output", ng - rd_ptr, 0);
    shift_bits(12'h9B4, 12'h361, 11, 12);
    drain(1'b0);
    expect_word(24'h9B4361, "R2 twelfth shift");

    // R3 extremes and sweep, dig_in garbage
    frame(1'b0, 12'hFFF, 12'h000, 12'hABC, 1'b0, "R3 ones/zeros");
    frame(1'b0, 12'h000, 12'hFFF, 12'h123, 1'b1, "R3 zeros/ones R7");
    for (int i = 0; i < 40; i++) begin
      a = 12'((i * 331 + 7) % 4096);
      b = 12'((i * 1237 + 2048) % 4096);
      d = 12'((i * 97) % 4096);
      frame(1'b0, a, b, d, i[0], "R3 analog sweep R7");
    end

    // R4 digital sweep, serial data garbage
    frame(1'b1, 12'hFFF, 12'hFFF, 12'hFFF, 1'b0, "R4 all ones");
    for (int i = 0; i < 40; i++) begin
      a = 12'((i * 555 + 3) % 4096);
      b = 12'((i * 911 + 17) % 4096);
      d = 12'((i * 173 + 1) % 4096);
      frame(1'b1, a, b, d, i[1], "R4 digital sweep R7");
    end
    check(!overrun, "R9 no false overrun", int'(overrun), 0);

    // R9: second word during a stalled packet is dropped
    @(negedge clk); fifo_full = 1'b1; dig_mode = 1'b0;
    shift_bits(12'h7E1, 12'h2D4, 0, 12);
    repeat (4) @(negedge clk);
    check(!overrun, "R9 no overrun before second word", int'(overrun), 0);
    shift_bits(12'h111, 12'h222, 0, 12);
    repeat (4) @(negedge clk);
    check(overrun, "R9 overrun set", int'(overrun), 1);
    check(ng == rd_ptr, "R7 no writes while full", ng - rd_ptr, 0);
    fifo_full = 1'b0;
    repeat (12) @(negedge clk);
    expect_word(24'h7E12D4, "R9 first word intact");
    frame(1'b0, 12'h3C3, 12'hC3C, 12'h000, 1'b0, "R9 after overrun");
    check(overrun, "R9 overrun sticky", int'(overrun), 1);
    do_reset();
    @(negedge clk);
    check(!overrun, "R1 reset clears overrun", int'(overrun), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule